// File: doc/BRIEF.md
# Per-Bit Access Control and Status Register Bank

This block holds a small bank of sixteen-bit management registers. Every bit has its own access rule, so one register can mix control bits that software writes, bits that follow live hardware state, and sticky event flags. Software reaches the bank through a plain register port: a 5-bit address, a write strobe with write data, and a read strobe with combinational read data. Hardware drives one event line, one condition line and one completion line per bit. A one-cycle soft-reset pulse returns every bit to its default, except the bits marked as kept across soft reset. The stored value of each bit is also driven out to the surrounding logic on `ctrl_q`.

Each bit's rule, reset default and soft-reset exemption come from package functions. The default map has four registers. Register 0 is control: bits 0-3 read/write, bits 4-5 read/write kept over soft reset (bit 4 defaults to 1), bit 6 self-clearing, bit 7 self-setting (default 1), bits 8-11 write-only, bits 12-15 reserved. Register 1 is events: bits 0-3 write-one-to-clear, bits 4-7 cleared by any write, bits 8-11 cleared by a read, bits 12-15 read-only. Register 2 is latches: bits 0-5 latch-high, bits 6-11 latch-low (default 1), bits 12-15 reserved. Register 3 and any higher register is read/write: bits 0-7 kept over soft reset, and the register defaults to 16'h3C5A. Bit n of register r is flat index r*16+n on `hw_set`, `hw_cond`, `sc_done` and `ctrl_q`.

Top module: `csr_bit_engine`

## Requirements
- R1: A write to a read/write bit (register 0 bits 0-5, register 3) replaces its value at the next clock edge; reads and `ctrl_q` then show the new value.
- R2: Reserved positions (register 0 bits 12-15, register 2 bits 12-15) read 0 and ignore writes. Write-only bits (register 0 bits 8-11) take written data into `ctrl_q` but always read 0.
- R3: Read-only bits (register 1 bits 12-15) read the live value of their `hw_cond` lines in the same cycle, ignore writes, and show 0 on `ctrl_q`.
- R4: A write-one-to-clear bit (register 1 bits 0-3) is set by a high `hw_set`. A write clears it only where the written data bit is 1, and a 0 leaves it unchanged.
- R5: A write-anything-to-clear bit (register 1 bits 4-7) is set by `hw_set`. Any write to register 1 clears it, whatever the data.
- R6: A clear-on-read bit (register 1 bits 8-11) is set by `hw_set` and ignores writes. A read returns the value it had before the clear, and the bit becomes 0 at the edge that ends the read-strobe cycle.
- R7: When a `hw_set` pulse meets a software or read clear of the same bit in the same cycle, the bit ends the cycle at 1.
- R8: A latch-high bit (register 2 bits 0-5) goes to 1 the edge after its `hw_cond` is 1 and stays 1 until register 2 is read. After the read it stays 1 if the condition is still 1, and otherwise goes to 0.
- R9: A latch-low bit (register 2 bits 6-11, default 1) goes to 0 the edge after its `hw_cond` is 0 and stays 0 until register 2 is read. After the read it returns to 1 only if the condition is 1.
- R10: Writing 1 to a self-clearing bit (register 0 bit 6) sets it for exactly one cycle. With `SC_USE_DONE`=1 it stays set until its `sc_done` line is high instead. Writing 0 has no effect.
- R11: Writing 0 to a self-setting bit (register 0 bit 7) clears it for exactly one cycle, after which it is 1 again. Writing 1 has no effect.
- R12: Hardware reset loads every bit's default. A `soft_rst` pulse does the same at the next edge for every bit except the kept ones (register 0 bits 4-5, register 3 bits 0-7), which hold their value. Soft reset takes priority over events and writes.
- R13: `rd_data` is 0 whenever `rd_en` is low or the address is at or above the register count. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Soft-reset pulse, one cycle |
| addr | input | 5 | Register address shared by read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid in the strobe cycle |
| hw_set | input | NUM_REGS*16 | Per-bit hardware set events |
| hw_cond | input | NUM_REGS*16 | Per-bit hardware condition levels |
| sc_done | input | NUM_REGS*16 | Per-bit completion for self-clearing bits |
| ctrl_q | output | NUM_REGS*16 | Stored value of every bit |

## Verification
On every cycle the assertions check several rules: a zero read bus outside strobes, zero reserved and write-only read fields, the live read-only field, set-wins on a sticky event bit, the latch-high hold, the one-cycle self-clear and self-set pulses, the post-read value of the clear-on-read field, and kept bits across soft reset. Other behaviour only the bench scenarios show. This includes the value returned before a clear-on-read, partial write-one-to-clear masks, latch-low recovery with the condition absent or present, and defaults reloaded across whole registers. The bench compares every bit of `ctrl_q` and `rd_data` against its own model on each cycle, both in directed sequences and in a long random mix.

// File: rtl/csr_pkg.sv
package csr_pkg;

  localparam int unsigned REG_W = 16;

  typedef enum logic [3:0] {
    ACC_RSV, ACC_RW, ACC_RO, ACC_WO, ACC_W1C, ACC_WAC,
    ACC_RC, ACC_LH, ACC_LL, ACC_SC, ACC_SS
  } acc_e;

  // Access rule of bit b in register r (demonstration map)
  function automatic acc_e map_acc(input int unsigned r, input int unsigned b);
    acc_e a;
    case (r)
      0: begin
        if (b < 6) a = ACC_RW;
        else if (b == 6) a = ACC_SC;
        else if (b == 7) a = ACC_SS;
        else if (b < 12) a = ACC_WO;
        else a = ACC_RSV;
      end
      1: begin
        if (b < 4) a = ACC_W1C;
        else if (b < 8) a = ACC_WAC;
        else if (b < 12) a = ACC_RC;
        else a = ACC_RO;
      end
      2: begin
        if (b < 6) a = ACC_LH;
        else if (b < 12) a = ACC_LL;
        else a = ACC_RSV;
      end
      default: a = ACC_RW;
    endcase
    return a;
  endfunction

  // Reset default of bit b in register r
  function automatic logic map_def(input int unsigned r, input int unsigned b);
    logic [REG_W-1:0] hi_def;
    hi_def = 16'h3C5A;
    case (r)
      0: return (b == 4) || (b == 7);
      1: return 1'b0;
      2: return (b >= 6) && (b < 12);
      default: return hi_def[b];
    endcase
  endfunction

  // Bit keeps its value across soft reset
  function automatic logic map_keep(input int unsigned r, input int unsigned b);
    case (r)
      0: return (b == 4) || (b == 5);
      1, 2: return 1'b0;
      default: return b < 8;
    endcase
  endfunction

endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_core_n = stage_q[1];
endmodule

// File: rtl/csr_bit_cell.sv
module csr_bit_cell #(
  parameter csr_pkg::acc_e ACC         = csr_pkg::ACC_RW,
  parameter logic          DEF         = 1'b0,
  parameter logic          KEEP        = 1'b0,
  parameter bit            SC_USE_DONE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic rd_hit,
  input  logic hw_set,
  input  logic hw_cond,
  input  logic sc_done,
  output logic state_q,
  output logic rd_val
);
  import csr_pkg::*;

  logic nxt;
  logic upd;
  logic sc_clr;

  assign sc_clr = SC_USE_DONE ? sc_done : 1'b1;

  always_comb begin
    nxt = state_q;
    case (ACC)
      ACC_RW, ACC_WO: if (wr_hit) nxt = wr_bit;
      ACC_W1C: nxt = hw_set | (state_q & ~(wr_hit & wr_bit));
      ACC_WAC: nxt = hw_set | (state_q & ~wr_hit);
      ACC_RC:  nxt = hw_set | (state_q & ~rd_hit);
      ACC_LH:  nxt = hw_cond | (state_q & ~rd_hit);
      ACC_LL:  nxt = hw_cond & (state_q | rd_hit);
      ACC_SC:  nxt = (wr_hit & wr_bit) | (state_q & ~sc_clr);
      ACC_SS:  nxt = ~(wr_hit & ~wr_bit);
      default: nxt = 1'b0;
    endcase
    if (soft_rst && !KEEP) nxt = DEF;
  end

  assign upd = (nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= DEF;
    else if (upd) state_q <= nxt;
  end

  always_comb begin
    case (ACC)
      ACC_RO:          rd_val = hw_cond;
      ACC_WO, ACC_RSV: rd_val = 1'b0;
      default:         rd_val = state_q;
    endcase
  end
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic [NUM_REGS*csr_pkg::REG_W-1:0] view,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               rd_en,
  output logic [csr_pkg::REG_W-1:0]          rd_data
);
  localparam int unsigned W = csr_pkg::REG_W;

  always_comb begin
    rd_data = '0;
    for (int unsigned r = 0; r < NUM_REGS; r++) begin
      if (rd_en && (addr == ADDR_W'(r))) rd_data = view[r*W +: W];
    end
  end
endmodule

// File: rtl/csr_bit_engine.sv
module csr_bit_engine #(
  parameter int unsigned NUM_REGS    = 4,
  parameter bit          SC_USE_DONE = 1'b0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               soft_rst,
  input  logic [4:0]                         addr,
  input  logic                               wr_en,
  input  logic [csr_pkg::REG_W-1:0]          wr_data,
  input  logic                               rd_en,
  output logic [csr_pkg::REG_W-1:0]          rd_data,
  input  logic [NUM_REGS*csr_pkg::REG_W-1:0] hw_set,
  input  logic [NUM_REGS*csr_pkg::REG_W-1:0] hw_cond,
  input  logic [NUM_REGS*csr_pkg::REG_W-1:0] sc_done,
  output logic [NUM_REGS*csr_pkg::REG_W-1:0] ctrl_q
);
  localparam int unsigned W      = csr_pkg::REG_W;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned NB     = NUM_REGS * W;

  logic          rst_core_n;
  logic [NB-1:0] view;

  csr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic wr_hit;
    logic rd_hit;
    assign wr_hit = wr_en && (addr == ADDR_W'(r));
    assign rd_hit = rd_en && (addr == ADDR_W'(r));
    for (genvar b = 0; b < W; b++) begin : g_bit
      csr_bit_cell #(
        .ACC         (csr_pkg::map_acc(r, b)),
        .DEF         (csr_pkg::map_def(r, b)),
        .KEEP        (csr_pkg::map_keep(r, b)),
        .SC_USE_DONE (SC_USE_DONE)
      ) u_cell (
        .clk      (clk),
        .rst_n    (rst_core_n),
        .soft_rst (soft_rst),
        .wr_hit   (wr_hit),
        .wr_bit   (wr_data[b]),
        .rd_hit   (rd_hit),
        .hw_set   (hw_set[r*W+b]),
        .hw_cond  (hw_cond[r*W+b]),
        .sc_done  (sc_done[r*W+b]),
        .state_q  (ctrl_q[r*W+b]),
        .rd_val   (view[r*W+b])
      );
    end
  end

  csr_read_mux #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_mux (
    .view    (view),
    .addr    (addr),
    .rd_en   (rd_en),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/csr_bit_engine_chk.sv
module csr_bit_engine_chk #(
  parameter int unsigned NUM_REGS    = 4,
  parameter bit          SC_USE_DONE = 1'b0
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   soft_rst,
  input logic [4:0]             addr,
  input logic                   wr_en,
  input logic [15:0]            wr_data,
  input logic                   rd_en,
  input logic [15:0]            rd_data,
  input logic [NUM_REGS*16-1:0] hw_set,
  input logic [NUM_REGS*16-1:0] hw_cond,
  input logic [NUM_REGS*16-1:0] ctrl_q
);
  p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |-> rd_data == 16'h0000);

  if (NUM_REGS >= 4) begin : g_map
    p_rsv_wo_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (rd_en && addr == 5'd0) |-> rd_data[15:8] == 8'h00);

    p_ro_live_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (rd_en && addr == 5'd1) |-> rd_data[15:12] == hw_cond[31:28]);

    p_rc_after_read_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (rd_en && addr == 5'd1 && !soft_rst) |=> ctrl_q[27:24] == $past(hw_set[27:24]));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (hw_set[16] && !soft_rst) |=> ctrl_q[16]);

    p_lh_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ctrl_q[32] && !soft_rst && !(rd_en && addr == 5'd2)) |=> ctrl_q[32]);

    if (!SC_USE_DONE) begin : g_sc
      p_sc_pulse_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (ctrl_q[6] && !(wr_en && addr == 5'd0 && wr_data[6])) |=> !ctrl_q[6]);
    end

    p_ss_return_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!ctrl_q[7] && !(wr_en && addr == 5'd0 && !wr_data[7])) |=> ctrl_q[7]);

    p_keep_soft_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (soft_rst && !(wr_en && addr == 5'd3)) |=> $stable(ctrl_q[55:48]));
  end
endmodule

bind csr_bit_engine csr_bit_engine_chk #(
  .NUM_REGS    (NUM_REGS),
  .SC_USE_DONE (SC_USE_DONE)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_core_n),
  .soft_rst   (soft_rst),
  .addr       (addr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .hw_set     (hw_set),
  .hw_cond    (hw_cond),
  .ctrl_q     (ctrl_q)
);

// File: tb/sim_csr_bit_engine.sv
`timescale 1ns/1ps
module sim_csr_bit_engine;
  import csr_pkg::*;

  localparam int NR = 4;
  localparam int NB = NR * 16;

  logic          clk = 1'b0;
  logic          rst_n, soft_rst, wr_en, rd_en;
  logic [4:0]    addr;
  logic [15:0]   wr_data, rd_data;
  logic [NB-1:0] hw_set, hw_cond, sc_done, ctrl_q;

  always #2.5 clk = ~clk;

  csr_bit_engine #(.NUM_REGS(NR), .SC_USE_DONE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .hw_set(hw_set), .hw_cond(hw_cond), .sc_done(sc_done), .ctrl_q(ctrl_q)
  );

  bit    mq[NB];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string tag = "R12";

  function automatic logic [15:0] model_read();
    logic [15:0] v = '0;
    if (rd_en && addr < NR) begin
      for (int b = 0; b < 16; b++) begin
        acc_e a = map_acc(addr, b);
        if (a == ACC_RO) v[b] = hw_cond[addr*16+b];
        else if (a == ACC_WO || a == ACC_RSV) v[b] = 1'b0;
        else v[b] = mq[addr*16+b];
      end
    end
    return v;
  endfunction

  function automatic logic [NB-1:0] model_q();
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = mq[i];
    return v;
  endfunction

  task automatic compare();
    logic [15:0]   er = model_read();
    logic [NB-1:0] eq = model_q();
    n_chk++;
    if (rd_data !== er) begin
      n_bad++;
      $display("FAIL %s rd_data addr=%0d actual=%h expected=%h", tag, addr, rd_data, er);
    end
    n_chk++;
    if (ctrl_q !== eq) begin
      n_bad++;
      $display("FAIL %s ctrl_q actual=%h expected=%h", tag, ctrl_q, eq);
    end
  endtask

  // Behavioural next state, one rule per requirement
  task automatic step_model();
    bit nq[NB];
    for (int i = 0; i < NB; i++) begin
      int r = i / 16;
      int b = i % 16;
      bit wh = wr_en && (addr == r);
      bit rh = rd_en && (addr == r);
      bit wb = wr_data[b];
      nq[i] = mq[i];
      case (map_acc(r, b))
        ACC_RW, ACC_WO: if (wh) nq[i] = wb;                       // R1 R2
        ACC_W1C: begin if (wh && wb) nq[i] = 0; if (hw_set[i]) nq[i] = 1; end // R4 R7
        ACC_WAC: begin if (wh) nq[i] = 0; if (hw_set[i]) nq[i] = 1; end       // R5 R7
        ACC_RC:  begin if (rh) nq[i] = 0; if (hw_set[i]) nq[i] = 1; end       // R6 R7
        ACC_LH:  begin if (rh) nq[i] = 0; if (hw_cond[i]) nq[i] = 1; end      // R8
        ACC_LL:  begin if (rh) nq[i] = 1; if (!hw_cond[i]) nq[i] = 0; end     // R9
        ACC_SC:  nq[i] = (wh && wb) ? 1 : 0;                      // R10
        ACC_SS:  nq[i] = (wh && !wb) ? 0 : 1;                     // R11
        default: nq[i] = 0;                                       // R2 R3
      endcase
      if (soft_rst && !map_keep(r, b)) nq[i] = map_def(r, b);    // R12
    end
    mq = nq;
  endtask

  task automatic tick();
    #1;
    compare();
    @(posedge clk);
    step_model();
    @(negedge clk);
  endtask

  task automatic idle_in();
    soft_rst = 0; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0; hw_set = '0;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    idle_in(); wr_en = 1; addr = 5'(a); wr_data = d; tick(); idle_in();
  endtask

  task automatic rd(input int a);
    idle_in(); rd_en = 1; addr = 5'(a); tick(); idle_in();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin idle_in(); tick(); end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_in(); hw_cond = '0; sc_done = '0;
    for (int i = 0; i < NB; i++) mq[i] = map_def(i / 16, i % 16);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R12: hardware reset defaults, with the latch-low conditions held high
    hw_cond[43:38] = '1;
    tag = "R12"; rd(0); rd(3); rd(2);

    tag = "R1"; wr(0, 16'h002B); rd(0); wr(3, 16'hFFFF); rd(3); wr(3, 16'h1234); rd(3);
    tag = "R2"; wr(0, 16'hFA00); rd(0); wr(2, 16'hF000); rd(2); wr(0, 16'h0500); rd(0);
    tag = "R3"; hw_cond[31:28] = 4'b1010; rd(1); wr(1, 16'hF000); rd(1);
    hw_cond[31:28] = 4'b0101; rd(1);
    tag = "R4"; idle_in(); hw_set[19:16] = 4'hF; tick(); idle_in();
    rd(1); wr(1, 16'h0005); rd(1); wr(1, 16'h000A); rd(1);
    tag = "R5"; idle_in(); hw_set[23:20] = 4'hF; hw_set[17] = 1; tick(); idle_in();
    rd(1); wr(1, 16'h0000); rd(1); wr(1, 16'h0002); rd(1);
    tag = "R6"; idle_in(); hw_set[27:24] = 4'h9; tick(); idle_in();
    wr(1, 16'h0F00); rd(1); rd(1);
    tag = "R7"; idle_in(); hw_set[16] = 1; hw_set[20] = 1; hw_set[24] = 1;
    wr_en = 1; addr = 1; wr_data = 16'h00FF; tick(); idle_in();
    rd(1); idle_in(); hw_set[25] = 1; rd_en = 1; addr = 1; tick(); idle_in(); rd(1);
    tag = "R8"; hw_cond[32] = 1; idle(1); hw_cond[32] = 0; idle(3); rd(2); rd(2);
    hw_cond[33] = 1; idle(2); rd(2); hw_cond[33] = 0; idle(1); rd(2); rd(2);
    tag = "R9"; hw_cond[38] = 0; idle(1); hw_cond[38] = 1; idle(2); rd(2); rd(2);
    hw_cond[40] = 0; idle(1); rd(2); hw_cond[40] = 1; rd(2); rd(2);
    tag = "R10"; wr(0, 16'h0040); idle(2); wr(0, 16'h0000); idle(1);
    tag = "R11"; wr(0, 16'h0000); idle(2); wr(0, 16'h0080); idle(1);
    tag = "R12"; wr(0, 16'h003F); wr(3, 16'hA5A5); hw_cond[34] = 1; idle(1);
    idle_in(); soft_rst = 1; hw_set[18] = 1; tick(); idle_in(); hw_cond[34] = 0;
    rd(0); rd(3); rd(1); rd(2);
    tag = "R13"; rd(4); rd(31); wr(7, 16'hFFFF); wr(4, 16'h0000); rd(0); idle(2);

    tag = "R7 random mix";
    for (int k = 0; k < 3000; k++) begin
      idle_in();
      addr = 5'($urandom_range(0, 5));
      wr_en = ($urandom_range(0, 3) == 0);
      rd_en = ($urandom_range(0, 2) == 0);
      wr_data = 16'($urandom);
      hw_set = {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) hw_cond = {$urandom, $urandom};
      soft_rst = ($urandom_range(0, 63) == 0);
      tick();
    end
    idle_in(); tick();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule